// File: doc/BRIEF.md
# Receive Carrier Presence Qualifier

This block decides whether a usable receive carrier is on the line. Each accepted sample carries a magnitude estimate of the received signal. The block squares each estimate and smooths the result with a first-order recursive average to give an energy level. It tests that level against a programmable upper threshold. It also tests it against a lower threshold that sits at half the upper one, which is about 3 dB lower in power. This hysteresis is built in and cannot be changed.

A transition in either direction must persist for a programmable number of samples before it takes effect. The carrier-detect output is active low. While no carrier is present, the block holds the received data output at mark (high), so the demodulator's raw decisions on noise never reach the data path.

Samples arrive on a valid/ready stream. The block never applies back-pressure in normal operation, so `s_ready` is high whenever the block is out of reset and not powered down. A sample counts only in a cycle where both `s_valid` and `s_ready` are high. Power-down drops `s_ready`, so samples offered during power-down are refused. The threshold and delay inputs are plain control levels.

Top module: `carrier_qualifier`

## Requirements
- R1: During reset and while `pwr_down` is high, `cd_n` reads 1 and `rxd` reads 1. Leaving power-down, the block starts again from zero energy with both timers at zero, so a full new qualifying run is needed before `cd_n` can go low.
- R2: For each accepted sample the energy accumulator `A` updates as `A <= A - (A >> SHIFT) + mag*mag`. The level for that sample is the new `A >> SHIFT`. With the default `SHIFT=3`, a constant magnitude `m` settles at a level of exactly `m*m`.
- R3: A sample counts as above the upper threshold only when its level is strictly greater than `thr`. A steady level equal to or just under `thr` never brings `cd_n` low.
- R4: With `cd_n` high, `cd_n` falls at the clock edge that accepts the (`assert_dly`+1)-th consecutive sample above the upper threshold.
- R5: While `cd_n` is high, any accepted sample that is not above the upper threshold resets the assert count to zero. A burst shorter than the assert delay therefore leaves `cd_n` high.
- R6: A sample counts as below the lower threshold only when its level is strictly less than `thr >> 1`. A level between the two thresholds keeps the present `cd_n` value indefinitely.
- R7: With `cd_n` low, `cd_n` rises at the clock edge that accepts the (`release_dly`+1)-th consecutive sample below the lower threshold. Any accepted sample that is not below the lower threshold resets the release count to zero, so a dip shorter than the release delay leaves `cd_n` low.
- R8: `rxd` equals `rxd_raw` while `cd_n` is 0, and is 1 while `cd_n` is 1.
- R9: `s_ready` is high exactly when the block is out of reset and `pwr_down` is low. `cd_n` changes only at an edge that accepts a sample, or when power-down or reset forces it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_down | input | 1 | Power-down: clears all state and refuses samples |
| s_valid | input | 1 | A magnitude sample is offered |
| s_ready | output | 1 | The block accepts the offered sample |
| s_mag | input | MAG_W | Unsigned receive magnitude estimate |
| thr | input | 2*MAG_W | Upper threshold in squared-magnitude units |
| assert_dly | input | DLY_W | Extra consecutive samples above `thr` required before `cd_n` falls |
| release_dly | input | DLY_W | Extra consecutive samples below `thr>>1` required before `cd_n` rises |
| rxd_raw | input | 1 | Raw demodulated data bit |
| cd_n | output | 1 | Carrier detect, active low |
| rxd | output | 1 | Gated received data, held at 1 without carrier |

## Verification
The assertions assume that `thr`, `assert_dly` and `release_dly` stay constant while samples flow. They also assume that `rxd_raw` and the stream inputs are known after reset. The stimulus changes the settings only in idle cycles or during power-down. It drives every input from the bench at the falling edge.

Directed runs place steady magnitudes one step above and below each threshold, and bursts and dips on either side of each delay. Random magnitudes, valid gaps and data bits then follow with the seed fixed.

// File: rtl/cdq_pkg.sv
package cdq_pkg;
  typedef enum logic {CDQ_IDLE = 1'b0, CDQ_LOCKED = 1'b1} cdq_state_e;

  function automatic int unsigned cdq_sq_width(input int unsigned mag_w);
    return 2 * mag_w;
  endfunction
endpackage

// File: rtl/cdq_energy.sv
module cdq_energy #(
  parameter int unsigned MAG_W = 12,
  parameter int unsigned SHIFT = 3,
  localparam int unsigned SQ_W  = cdq_pkg::cdq_sq_width(MAG_W),
  localparam int unsigned ACC_W = SQ_W + SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  input  logic [MAG_W-1:0] mag,
  output logic [SQ_W-1:0]  level_nx
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_nx;
  logic [SQ_W-1:0]  sq;

  always_comb begin
    sq       = SQ_W'(mag) * SQ_W'(mag);
    acc_nx   = acc_q - (acc_q >> SHIFT) + ACC_W'(sq);
    level_nx = acc_nx[ACC_W-1:SHIFT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '0;
    else if (clr)  acc_q <= '0;
    else if (take) acc_q <= acc_nx;
  end
endmodule

// File: rtl/cdq_timer.sv
module cdq_timer #(
  parameter int unsigned DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             cond,
  input  logic [DLY_W-1:0] limit,
  output logic             fire
);
  logic [DLY_W-1:0] cnt_q;

  assign fire = step && cond && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (clr)         cnt_q <= '0;
    else if (step) begin
      if (cond && !fire)  cnt_q <= cnt_q + 1'b1;
      else                cnt_q <= '0;
    end
  end
endmodule

// File: rtl/carrier_qualifier.sv
module carrier_qualifier #(
  parameter int unsigned MAG_W = 12,
  parameter int unsigned SHIFT = 3,
  parameter int unsigned DLY_W = 16,
  localparam int unsigned SQ_W = cdq_pkg::cdq_sq_width(MAG_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_down,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [MAG_W-1:0] s_mag,
  input  logic [SQ_W-1:0]  thr,
  input  logic [DLY_W-1:0] assert_dly,
  input  logic [DLY_W-1:0] release_dly,
  input  logic             rxd_raw,
  output logic             cd_n,
  output logic             rxd
);
  import cdq_pkg::*;

  cdq_state_e      state_q;
  logic            take;
  logic [SQ_W-1:0] level_nx;
  logic            hi_ok, lo_ok;
  logic            on_fire, off_fire;

  assign s_ready = rst_n && !pwr_down;
  assign take    = s_valid && s_ready;

  cdq_energy #(.MAG_W(MAG_W), .SHIFT(SHIFT)) u_energy (
    .clk(clk), .rst_n(rst_n), .clr(pwr_down), .take(take),
    .mag(s_mag), .level_nx(level_nx)
  );

  assign hi_ok = level_nx > thr;
  assign lo_ok = level_nx < (thr >> 1);

  cdq_timer #(.DLY_W(DLY_W)) u_on_timer (
    .clk(clk), .rst_n(rst_n),
    .clr(pwr_down || state_q == CDQ_LOCKED),
    .step(take), .cond(hi_ok), .limit(assert_dly), .fire(on_fire)
  );

  cdq_timer #(.DLY_W(DLY_W)) u_off_timer (
    .clk(clk), .rst_n(rst_n),
    .clr(pwr_down || state_q == CDQ_IDLE),
    .step(take), .cond(lo_ok), .limit(release_dly), .fire(off_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    state_q <= CDQ_IDLE;
    else if (pwr_down)                             state_q <= CDQ_IDLE;
    else if (state_q == CDQ_IDLE && on_fire)       state_q <= CDQ_LOCKED;
    else if (state_q == CDQ_LOCKED && off_fire)    state_q <= CDQ_IDLE;
  end

  assign cd_n = (state_q == CDQ_IDLE);
  assign rxd  = cd_n ? 1'b1 : rxd_raw;
endmodule

// File: rtl/cdq_checker.sv
module cdq_checker #(
  parameter int unsigned SQ_W = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pwr_down,
  input logic            s_valid,
  input logic            s_ready,
  input logic            cd_n,
  input logic            rxd_raw,
  input logic            rxd,
  input logic [SQ_W-1:0] level_nx,
  input logic [SQ_W-1:0] thr
);
  a_r1_pd_forces_idle: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> cd_n);

  a_r4_fall_needs_high_level: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cd_n) |-> $past(s_valid && s_ready && level_nx > thr));

  a_r7_rise_needs_low_level: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cd_n) |-> $past(pwr_down || (s_valid && s_ready && level_nx < (thr >> 1))));

  a_r9_still_without_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (!(s_valid && s_ready) && !pwr_down) |=> $stable(cd_n));

  a_r8_mark_without_carrier: assert property (@(posedge clk) disable iff (!rst_n)
    cd_n |-> rxd);

  a_r9_refuse_in_pd: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> !s_ready);
endmodule

bind carrier_qualifier cdq_checker #(.SQ_W(SQ_W)) u_cdq_chk (
  .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .s_valid(s_valid),
  .s_ready(s_ready), .cd_n(cd_n), .rxd_raw(rxd_raw), .rxd(rxd),
  .level_nx(level_nx), .thr(thr)
);

// File: tb/carrier_qualifier_test.sv
module carrier_qualifier_test;
  localparam int MAG_W = 12, SHIFT = 3, DLY_W = 16, SQ_W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_down = 1'b0, s_valid = 1'b0, rxd_raw = 1'b0;
  logic s_ready, cd_n, rxd;
  logic [MAG_W-1:0] s_mag = '0;
  logic [SQ_W-1:0]  thr = '0;
  logic [DLY_W-1:0] assert_dly = '0, release_dly = '0;

  int errors = 0, checks = 0;
  bit done = 0;

  longint m_acc = 0;
  bit     m_car = 0;
  longint m_ac = 0, m_rc = 0;

  always #10 clk = ~clk;

  carrier_qualifier #(.MAG_W(MAG_W), .SHIFT(SHIFT), .DLY_W(DLY_W)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .s_valid(s_valid),
    .s_ready(s_ready), .s_mag(s_mag), .thr(thr), .assert_dly(assert_dly),
    .release_dly(release_dly), .rxd_raw(rxd_raw), .cd_n(cd_n), .rxd(rxd)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint model_level(input longint acc, input longint mag);
    return (acc - (acc >> SHIFT) + mag * mag) >> SHIFT;
  endfunction

  task automatic model_take(input longint mag);
    longint lvl;
    lvl   = model_level(m_acc, mag);
    m_acc = m_acc - (m_acc >> SHIFT) + mag * mag;
    if (!m_car) begin
      m_rc = 0;
      if (lvl > longint'(thr)) begin
        if (m_ac == longint'(assert_dly)) begin m_car = 1; m_ac = 0; end
        else m_ac++;
      end else m_ac = 0;
    end else begin
      m_ac = 0;
      if (lvl < longint'(thr >> 1)) begin
        if (m_rc == longint'(release_dly)) begin m_car = 0; m_rc = 0; end
        else m_rc++;
      end else m_rc = 0;
    end
  endtask

  task automatic step(input int mag, input bit raw, input bit v, input string tag);
    s_mag = MAG_W'(mag); rxd_raw = raw; s_valid = v;
    @(posedge clk);
    if (v && !pwr_down) model_take(mag);
    @(negedge clk);
    check(cd_n == !m_car, tag, cd_n, !m_car);
    check(rxd == (m_car ? raw : 1'b1), {tag, " R8"}, rxd, m_car ? raw : 1'b1);
  endtask

  task automatic run(input int n, input int mag, input string tag);
    for (int i = 0; i < n; i++) step(mag, i[0], 1'b1, tag);
  endtask

  task automatic power_cycle();
    pwr_down = 1'b1; s_valid = 1'b1; s_mag = 12'd4095;
    @(posedge clk);
    m_acc = 0; m_car = 0; m_ac = 0; m_rc = 0;
    @(negedge clk);
    check(s_ready == 1'b0, "R9 ready low in power-down", s_ready, 0);
    check(cd_n == 1'b1, "R1 power-down idle", cd_n, 1);
    pwr_down = 1'b0; s_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit hold;
    void'($urandom(32'd1234));
    thr = 24'd10000; assert_dly = 16'd5; release_dly = 16'd5;
    repeat (3) @(negedge clk);
    check(cd_n == 1 && rxd == 1, "R1 reset state", {cd_n, rxd}, 3);
    rst_n = 1'b1;
    @(negedge clk);
    check(s_ready == 1, "R9 ready after reset", s_ready, 1);

    // R3: steady 99^2=9801 < 10000 never asserts
    run(200, 99, "R3 just below upper");
    check(cd_n == 1, "R3 no carrier at 9801", cd_n, 1);
    // R3/R4: 101^2=10201 > thr asserts
    run(200, 101, "R4 just above upper");
    check(cd_n == 0, "R4 carrier at 10201", cd_n, 0);
    // R6: 71^2=5041 within band keeps carrier
    run(300, 71, "R6 band");
    check(cd_n == 0, "R6 band holds carrier", cd_n, 0);
    // R6/R7: 70^2=4900 < 5000 releases
    run(200, 70, "R7 just below lower");
    check(cd_n == 1, "R7 release at 4900", cd_n, 1);
    // R6: band does not assert from idle
    run(300, 71, "R6 band idle");
    check(cd_n == 1, "R6 band keeps idle", cd_n, 1);
    // R2: steady level equals m^2 exactly: 100^2 = thr not above
    run(300, 100, "R2 steady equals thr");
    check(cd_n == 1, "R2 level m*m not above thr", cd_n, 1);

    power_cycle();
    @(negedge clk);
    thr = 24'd2000000; assert_dly = 16'd60; release_dly = 16'd30;
    // R5: short burst
    run(3, 4095, "R5 short burst");
    run(100, 0, "R5 after short burst");
    check(cd_n == 1, "R5 short burst ignored", cd_n, 1);
    // R4: long burst
    run(100, 4095, "R4 long burst");
    check(cd_n == 0, "R4 long burst asserts", cd_n, 0);
    // R7: short dip then recover
    run(25, 0, "R7 short dip");
    run(60, 4095, "R7 recover");
    check(cd_n == 0, "R7 short dip held", cd_n, 0);
    // R8 rxd follows raw with carrier
    step(4095, 1'b0, 1'b1, "R8 raw0");
    check(rxd == 0, "R8 raw passes", rxd, 0);
    // R9: no valid, no change
    step(0, 1'b1, 1'b0, "R9 idle no sample");
    check(cd_n == 0, "R9 idle keeps", cd_n, 0);
    // R7 long silence releases
    run(120, 0, "R7 long silence");
    check(cd_n == 1, "R7 long silence releases", cd_n, 1);
    // R1: power-down clears energy
    run(100, 4095, "R1 prep");
    power_cycle();
    check(cd_n == 1 && rxd == 1, "R1 cleared after pd", {cd_n, rxd}, 3);
    run(60, 4095, "R1 fresh run needed");
    check(cd_n == 1, "R1 60 samples insufficient", cd_n, 1);

    // random phase
    assert_dly = 16'd4; release_dly = 16'd4; thr = 24'd1000000;
    @(negedge clk);
    for (int i = 0; i < 3000; i++) begin
      hold = ($urandom % 4) != 0;
      step(($urandom % 2) ? int'($urandom % 4096) : int'($urandom % 800),
           1'($urandom), hold, "R2 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule